// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Unit

This unit keeps the statistics counters of an Ethernet MAC. The transmit and receive paths each report a finished frame as a single-cycle event. The event carries the frame length in bytes, a bad-FCS flag, a VLAN-tag flag, the destination address class, a control-frame flag (raised when the EtherType is 0x8808) and the 16-bit control opcode.

A classifier turns each event into a set of increment strobes. A counter bank applies those strobes on the next clock edge. Transmit and receive frames feed the same seven size bins. A further eight counters see only received frames.

Every counter is 32 bits wide and sits on a simple word-aligned register bus. Software can read it and write it. Reads are combinational from the address.

Top module: `frame_stats_unit`

## Requirements
- R1: A frame from either direction (evIsRx 0 = transmit, 1 = receive) increments exactly one size bin when its length falls into one of these ranges: 64, 65–127, 128–255, 256–511, 512–1023 or 1024–1518. The bins sit at 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94. Any other length touches none of these bins.
- R2: The bin at 0x98 increments only for a frame that has good FCS, the VLAN flag set and a length from 1519 to 1522.
- R3: The byte counter at 0x9C adds the length of every received frame, whatever its status. It wraps modulo 2^32.
- R4: The packet counter at 0xA0 increments for every received frame. A transmitted frame changes none of the counters from 0x9C to 0xB8.
- R5: The FCS error counter at 0xA4 increments for a received frame that has bad FCS and a length from 64 to 1518.
- R6: The multicast counter at 0xA8 increments for a received good frame whose class code is 2'b01. The length must be below 1518 when untagged and below 1522 when VLAN-tagged. Class 2'b00 is unicast and 2'b10 is broadcast; neither counts here.
- R7: The broadcast counter at 0xAC obeys the same good-frame length limits, for class code 2'b10 only.
- R8: The control frame counter at 0xB0 increments for every received frame that has the control flag set.
- R9: The pause counter at 0xB4 increments for a received control frame with good FCS and opcode 0x0001. The unknown-opcode counter at 0xB8 increments for a received control frame with any other opcode.
- R10: A counter at offset 0x80 + 4·n (n = 0..14) reads back the value last written to it. Reads of unmapped or misaligned addresses return zero. Writes to such addresses change no counter.
- R11: Every counter except the byte counter saturates at 0xFFFFFFFF.
- R12: When a bus write and an increment reach the same counter in the same cycle, the written value is kept.
- R13: After reset every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Frame completion event strobe |
| evIsRx | input | 1 | 1 = received frame, 0 = transmitted frame |
| evLen | input | 16 | Frame length in bytes |
| evFcsBad | input | 1 | Frame has an FCS error |
| evVlan | input | 1 | Frame carries a VLAN tag |
| evDaClass | input | 2 | Destination class: 00 unicast, 01 multicast, 10 broadcast |
| evCtrl | input | 1 | MAC control frame (EtherType 0x8808) |
| evOpcode | input | 16 | Control opcode |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr |

## Verification
The bench sends transmit frames across every bin edge: 63, 64, 65, 127, 128, 1518 and 1519 bytes, plus oversize frames. These tell the bin boundaries apart and show that transmit leaves the receive counters alone.

Received frames mix the FCS, VLAN, class and control flags. The VLAN lengths 1517, 1518, 1521 and 1522 separate the tagged and untagged limits of the multicast and broadcast counters from the VLAN bin window. Pause frames with good and bad FCS, and other opcodes, separate the pause counter from the unknown-opcode counter.

Pre-loaded counter values near all-ones tell wrap from saturation. A write issued in the same cycle as a matching event tells write priority from increment priority.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int NUM_BINS = 7;
  localparam int NUM_RX   = 8;
  localparam int NUM_CNT  = NUM_BINS + NUM_RX;

  // counter slot order follows the address map
  localparam int IDX_BYTES = NUM_BINS;
  localparam int IDX_PKTS  = NUM_BINS + 1;
  localparam int IDX_FCS   = NUM_BINS + 2;
  localparam int IDX_MCAST = NUM_BINS + 3;
  localparam int IDX_BCAST = NUM_BINS + 4;
  localparam int IDX_CTRL  = NUM_BINS + 5;
  localparam int IDX_PAUSE = NUM_BINS + 6;
  localparam int IDX_UNKOP = NUM_BINS + 7;

  typedef enum logic [1:0] {
    DA_UNICAST   = 2'b00,
    DA_MULTICAST = 2'b01,
    DA_BROADCAST = 2'b10
  } daClass_e;

  typedef struct packed {
    logic [NUM_BINS-1:0] binInc;
    logic rxBytes;
    logic rxPkt;
    logic fcsErr;
    logic mcast;
    logic bcast;
    logic ctrlFrm;
    logic pause;
    logic unkOp;
  } strobe_t;
endpackage

// File: rtl/fsu_ctrl.sv
module fsu_ctrl
  import fsu_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int OP_W      = 16,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int MAX_VLEN  = 1522,
  parameter int PAUSE_OP  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic             evIsRx,
  input  logic [LEN_W-1:0] evLen,
  input  logic             evFcsBad,
  input  logic             evVlan,
  input  logic [1:0]       evDaClass,
  input  logic             evCtrl,
  input  logic [OP_W-1:0]  evOpcode,
  output strobe_t          strobes
);
  // lower edges of bins 1..5; bin 0 is exactly MIN_LEN
  localparam int BIN_LO1 = MIN_LEN + 1;
  localparam int BIN_LO2 = 2 * MIN_LEN;
  localparam int BIN_LO3 = 4 * MIN_LEN;
  localparam int BIN_LO4 = 8 * MIN_LEN;
  localparam int BIN_LO5 = 16 * MIN_LEN;
  localparam int VLAN_LO = MAX_LEN + 1;

  logic [NUM_BINS-1:0] inBin;
  logic good, rxEv, lenOkMc, inErrWin, isPause;

  always_comb begin
    good     = !evFcsBad;
    rxEv     = evValid && evIsRx;
    inBin[0] = (evLen == LEN_W'(MIN_LEN));
    inBin[1] = (evLen >= LEN_W'(BIN_LO1)) && (evLen < LEN_W'(BIN_LO2));
    inBin[2] = (evLen >= LEN_W'(BIN_LO2)) && (evLen < LEN_W'(BIN_LO3));
    inBin[3] = (evLen >= LEN_W'(BIN_LO3)) && (evLen < LEN_W'(BIN_LO4));
    inBin[4] = (evLen >= LEN_W'(BIN_LO4)) && (evLen < LEN_W'(BIN_LO5));
    inBin[5] = (evLen >= LEN_W'(BIN_LO5)) && (evLen <= LEN_W'(MAX_LEN));
    inBin[6] = good && evVlan && (evLen >= LEN_W'(VLAN_LO)) && (evLen <= LEN_W'(MAX_VLEN));
    lenOkMc  = evVlan ? (evLen < LEN_W'(MAX_VLEN)) : (evLen < LEN_W'(MAX_LEN));
    inErrWin = (evLen >= LEN_W'(MIN_LEN)) && (evLen <= LEN_W'(MAX_LEN));
    isPause  = (evOpcode == OP_W'(PAUSE_OP));

    strobes.binInc  = evValid ? inBin : '0;
    strobes.rxBytes = rxEv;
    strobes.rxPkt   = rxEv;
    strobes.fcsErr  = rxEv && evFcsBad && inErrWin;
    strobes.mcast   = rxEv && good && lenOkMc && (evDaClass == DA_MULTICAST);
    strobes.bcast   = rxEv && good && lenOkMc && (evDaClass == DA_BROADCAST);
    strobes.ctrlFrm = rxEv && evCtrl;
    strobes.pause   = rxEv && evCtrl && good && isPause;
    strobes.unkOp   = rxEv && evCtrl && !isPause;
  end

  // R1
  bin_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.binInc));

  // R4
  tx_no_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evIsRx) |-> !(strobes.rxBytes || strobes.rxPkt || strobes.fcsErr ||
                               strobes.mcast || strobes.bcast || strobes.ctrlFrm ||
                               strobes.pause || strobes.unkOp));

  // R7
  mc_bc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.mcast && strobes.bcast));

  // R9
  pause_unk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.pause && strobes.unkOp));

  // R8
  ctrl_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pause || strobes.unkOp) |-> strobes.ctrlFrm);

  // R5
  fcs_bad_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fcsErr |-> !(strobes.mcast || strobes.bcast || strobes.pause));
endmodule

// File: rtl/fsu_dpath.sv
module fsu_dpath
  import fsu_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int LEN_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [LEN_W-1:0]  evLen,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData
);
  localparam int IDX_W = $clog2(NUM_CNT);
  localparam int WRD_W = ADDR_W - 2;

  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [NUM_CNT-1:0] incVec;
  logic [NUM_CNT-1:0] wrSel;
  logic [ADDR_W-1:0]  offs;
  logic [WRD_W-1:0]   wordIdx;
  logic               hit;

  always_comb begin
    incVec[NUM_BINS-1:0] = strobes.binInc;
    incVec[IDX_BYTES]    = strobes.rxBytes;
    incVec[IDX_PKTS]     = strobes.rxPkt;
    incVec[IDX_FCS]      = strobes.fcsErr;
    incVec[IDX_MCAST]    = strobes.mcast;
    incVec[IDX_BCAST]    = strobes.bcast;
    incVec[IDX_CTRL]     = strobes.ctrlFrm;
    incVec[IDX_PAUSE]    = strobes.pause;
    incVec[IDX_UNKOP]    = strobes.unkOp;
  end

  always_comb begin
    offs    = busAddr - ADDR_W'(BASE_ADDR);
    wordIdx = offs[ADDR_W-1:2];
    hit     = (busAddr >= ADDR_W'(BASE_ADDR)) && (offs[1:0] == 2'b00) &&
              (wordIdx < WRD_W'(NUM_CNT));
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign wrSel[i] = busWrEn && hit && (wordIdx == WRD_W'(i));

    if (i == IDX_BYTES) begin : g_wrap
      always_ff @(posedge clk) begin
        if (!rstN)          cnt[i] <= '0;
        else if (wrSel[i])  cnt[i] <= busWrData;
        else if (incVec[i]) cnt[i] <= cnt[i] + CNT_W'(evLen);
      end
    end else begin : g_sat
      always_ff @(posedge clk) begin
        if (!rstN)                           cnt[i] <= '0;
        else if (wrSel[i])                   cnt[i] <= busWrData;
        else if (incVec[i] && cnt[i] != '1)  cnt[i] <= cnt[i] + 1'b1;
      end

      // R11
      sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cnt[i] == '1 && !wrSel[i]) |=> (cnt[i] == '1));
    end

    // R12
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrSel[i] |=> (cnt[i] == $past(busWrData)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!wrSel[i] && !incVec[i]) |=> $stable(cnt[i]));
  end

  always_comb begin
    busRdData = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (hit && wordIdx == WRD_W'(k)) busRdData = cnt[k];
  end

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (busRdData == '0));

  // R13
  reset_zero_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (cnt[IDX_PKTS] == '0 && cnt[IDX_BYTES] == '0));
endmodule

// File: rtl/frame_stats_unit.sv
module frame_stats_unit
  import fsu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 16,
  parameter int OP_W   = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic              evIsRx,
  input  logic [LEN_W-1:0]  evLen,
  input  logic              evFcsBad,
  input  logic              evVlan,
  input  logic [1:0]        evDaClass,
  input  logic              evCtrl,
  input  logic [OP_W-1:0]   evOpcode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData
);
  strobe_t strobes;

  fsu_ctrl #(.LEN_W(LEN_W), .OP_W(OP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evIsRx(evIsRx), .evLen(evLen),
    .evFcsBad(evFcsBad), .evVlan(evVlan), .evDaClass(evDaClass), .evCtrl(evCtrl),
    .evOpcode(evOpcode), .strobes(strobes)
  );

  fsu_dpath #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evLen(evLen), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );
endmodule

// File: tb/frame_stats_unit_tb.sv
module frame_stats_unit_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        evValid = 0, evIsRx = 0, evFcsBad = 0, evVlan = 0, evCtrl = 0;
  logic [15:0] evLen = 0, evOpcode = 0;
  logic [1:0]  evDaClass = 0;
  logic [7:0]  busAddr = 0;
  logic        busWrEn = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;

  int checks = 0, failures = 0;
  logic [31:0] mdl [15];
  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdReq = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  frame_stats_unit u_dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evIsRx(evIsRx), .evLen(evLen),
    .evFcsBad(evFcsBad), .evVlan(evVlan), .evDaClass(evDaClass), .evCtrl(evCtrl),
    .evOpcode(evOpcode), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  function automatic string tagOf(int idx);
    case (idx)
      0, 1, 2, 3, 4, 5: return "R1";
      6:  return "R2";
      7:  return "R3";
      8:  return "R4";
      9:  return "R5";
      10: return "R6";
      11: return "R7";
      12: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] satInc(logic [31:0] v);
    return (v == 32'hFFFF_FFFF) ? v : v + 1;
  endfunction

  // expected effect of one frame, from the requirement text
  task automatic modelFrame(bit rx, int len, bit bad, bit vlan, int cls, bit ctl, int op);
    if (len == 64) mdl[0] = satInc(mdl[0]);
    else if (len >= 65 && len <= 127) mdl[1] = satInc(mdl[1]);
    else if (len >= 128 && len <= 255) mdl[2] = satInc(mdl[2]);
    else if (len >= 256 && len <= 511) mdl[3] = satInc(mdl[3]);
    else if (len >= 512 && len <= 1023) mdl[4] = satInc(mdl[4]);
    else if (len >= 1024 && len <= 1518) mdl[5] = satInc(mdl[5]);
    else if (!bad && vlan && len >= 1519 && len <= 1522) mdl[6] = satInc(mdl[6]);
    if (rx) begin
      mdl[7] = mdl[7] + 32'(len);
      mdl[8] = satInc(mdl[8]);
      if (bad && len >= 64 && len <= 1518) mdl[9] = satInc(mdl[9]);
      if (!bad && cls == 1 && len < (vlan ? 1522 : 1518)) mdl[10] = satInc(mdl[10]);
      if (!bad && cls == 2 && len < (vlan ? 1522 : 1518)) mdl[11] = satInc(mdl[11]);
      if (ctl) mdl[12] = satInc(mdl[12]);
      if (ctl && !bad && op == 1) mdl[13] = satInc(mdl[13]);
      if (ctl && op != 1) mdl[14] = satInc(mdl[14]);
    end
  endtask

  task automatic driveEv(bit rx, int len, bit bad, bit vlan, int cls, bit ctl, int op);
    evValid = 1; evIsRx = rx; evLen = 16'(len); evFcsBad = bad; evVlan = vlan;
    evDaClass = 2'(cls); evCtrl = ctl; evOpcode = 16'(op);
    modelFrame(rx, len, bad, vlan, cls, ctl, op);
  endtask

  task automatic sendEv(bit rx, int len, bit bad, bit vlan, int cls, bit ctl, int op);
    @(negedge clk);
    driveEv(rx, len, bad, vlan, cls, ctl, op);
    @(negedge clk);
    evValid = 0;
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    if (a >= 8'h80 && a <= 8'hB8 && a[1:0] == 2'b00) mdl[(a - 8'h80) >> 2] = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  // scoreboard driver side: set address, push expected item
  task automatic readChk(logic [7:0] a, logic [31:0] e, string tag);
    @(posedge clk);
    busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdReq = 1;
    @(negedge clk);
    #1 rdReq = 0;
  endtask

  task automatic readAll(string ctx);
    for (int i = 0; i < 15; i++)
      readChk(8'(8'h80 + 4 * i), mdl[i], {tagOf(i), " ", ctx});
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rdReq && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, busAddr, busRdData, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R13 reset state
    readAll("reset");

    // R1 transmit across bin edges; R4 rx counters unchanged
    sendEv(0, 63, 0, 0, 0, 0, 0);
    sendEv(0, 64, 0, 0, 0, 0, 0);
    sendEv(0, 65, 0, 0, 1, 0, 0);
    sendEv(0, 127, 0, 0, 0, 0, 0);
    sendEv(0, 128, 1, 0, 2, 0, 0);
    sendEv(0, 255, 0, 0, 0, 0, 0);
    sendEv(0, 300, 0, 0, 0, 0, 0);
    sendEv(0, 1000, 0, 0, 0, 0, 0);
    sendEv(0, 1518, 0, 0, 0, 0, 0);
    sendEv(0, 1519, 0, 0, 0, 0, 0);
    sendEv(0, 1520, 0, 1, 0, 1, 1);
    readAll("tx");

    // receive mixes: R2 R3 R5 R6 R7
    sendEv(1, 64, 1, 0, 0, 0, 0);
    sendEv(1, 63, 1, 0, 0, 0, 0);
    sendEv(1, 1518, 1, 0, 1, 0, 0);
    sendEv(1, 1519, 1, 0, 0, 0, 0);
    sendEv(1, 1520, 0, 1, 1, 0, 0);
    sendEv(1, 1521, 1, 1, 2, 0, 0);
    sendEv(1, 1522, 0, 1, 2, 0, 0);
    sendEv(1, 1523, 0, 1, 0, 0, 0);
    sendEv(1, 1517, 0, 0, 1, 0, 0);
    sendEv(1, 1518, 0, 0, 1, 0, 0);
    sendEv(1, 1517, 0, 0, 2, 0, 0);
    sendEv(1, 1521, 0, 1, 2, 0, 0);
    sendEv(1, 200, 0, 0, 3, 0, 0);
    sendEv(1, 40, 0, 0, 1, 0, 0);
    // R8 R9 control frames
    sendEv(1, 64, 0, 0, 1, 1, 1);
    sendEv(1, 64, 1, 0, 1, 1, 1);
    sendEv(1, 64, 0, 0, 1, 1, 2);
    sendEv(1, 64, 0, 0, 0, 1, 16'h0101);
    sendEv(1, 64, 0, 0, 0, 0, 1);
    readAll("rx");

    // R10 write/readback and unmapped access
    for (int i = 0; i < 15; i++) busWrite(8'(8'h80 + 4 * i), 32'h1000_0000 + 32'(i * 17));
    busWrite(8'h82, 32'hDEAD_BEEF);
    busWrite(8'hBC, 32'hDEAD_BEEF);
    busWrite(8'h7C, 32'hDEAD_BEEF);
    readAll("R10 rw");
    readChk(8'hBC, 32'h0, "R10 unmapped");
    readChk(8'h7C, 32'h0, "R10 below base");
    readChk(8'h86, 32'h0, "R10 misaligned");

    // R11 saturation, R3 wrap
    busWrite(8'hA0, 32'hFFFF_FFFF);
    busWrite(8'h80, 32'hFFFF_FFFF);
    busWrite(8'h9C, 32'hFFFF_FFF0);
    sendEv(1, 64, 1, 0, 0, 0, 0);
    readChk(8'hA0, 32'hFFFF_FFFF, "R11 pkt sat");
    readChk(8'h80, 32'hFFFF_FFFF, "R11 bin sat");
    readChk(8'h9C, 32'h0000_0030, "R3 byte wrap");
    readChk(8'hA4, mdl[9], "R5 after sat");

    // R12 write coinciding with increment
    @(negedge clk);
    driveEv(1, 100, 0, 0, 1, 0, 0);
    busAddr = 8'hA8; busWrData = 32'h0000_0055; busWrEn = 1;
    mdl[10] = 32'h0000_0055;
    @(negedge clk);
    evValid = 0; busWrEn = 0;
    readChk(8'hA8, 32'h0000_0055, "R12 write wins mcast");
    readChk(8'h84, mdl[1], "R12 other bin still counts");
    readChk(8'hA0, 32'hFFFF_FFFF, "R12 pkt still sat");

    done = 1;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule